// File: doc/BRIEF.md
# Segmented Three-Tap Equalizer Data Mapper

This block sits in front of a transmit driver that is built from identical slices and carries data as two lanes per half-rate clock. Each cycle it takes a two-bit word (bit 0 is the even lane and leaves first in serial time; bit 1 is the odd lane). It lines the serial stream up into three bit pairs: the pre-cursor (the next serial bit), the main cursor (the current bit) and the post-cursor (the previous serial bit). For every driver slice and lane it then drives a pull-up control that is active low and a pull-down control that is active high.

The equalizer weights come only from how many slices each tap owns. Software writes three counts (pre, main, post). The block rejects a write whose total exceeds the slice count and keeps the previous legal split. Slices are handed out by index: the main slices come first, then the pre slices, then the post slices, and every slice above that stays idle. Selection gating is applied at the first stage: a NAND of select and data forms the pull-up control and a NOR forms the pull-down control. An idle slice therefore never toggles. Pre and post slices drive the inverted bit, which gives de-emphasis.

Top module: `eqmap_seg_mapper`

## Requirements
- R1: While reset is asserted and right after it, every pull-up control reads 1, every pull-down control reads 0 and all tap pairs read 0. The allocation defaults to main = NSEG, pre = 0, post = 0.
- R2: Let W(n) be the word sampled at clock edge n. After edge n the tap outputs are main = W(n-1), pre = {W(n)[0], W(n-1)[1]} and post = {W(n-1)[0], W(n-2)[1]}, written as {odd, even}.
- R3: Slice i is a main slice if i < main. It is a pre slice if main <= i < main+pre, and a post slice if main+pre <= i < main+pre+post. Any other slice is idle.
- R4: For each lane, a main slice uses the true main bit, and pre and post slices use the inverted pre or post bit. When the used bit is 1 the pull-up control is 0 and the pull-down is 0. When the used bit is 0 the pull-up control is 1 and the pull-down is 1.
- R5: An idle slice holds pull-up control 1 and pull-down 0, whatever the data.
- R6: On no slice and no lane are the pull-up (0) and the pull-down (1) active in the same cycle.
- R7: A write with pre+main+post > NSEG is ignored, and the slice outputs keep following the last legal allocation.
- R8: A legal write sampled at edge k changes the slice outputs registered at edge k+1. The outputs registered at edge k still use the old allocation.
- R9: Counts of zero are legal, and a total of exactly NSEG is legal. This includes an all-zero allocation, which leaves every slice idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| word_i | input | 2 | Data word, bit 0 even lane, bit 1 odd lane |
| cfg_wr_i | input | 1 | Allocation write strobe |
| cfg_pre_i | input | CW | Requested pre-cursor slice count |
| cfg_main_i | input | CW | Requested main slice count |
| cfg_post_i | input | CW | Requested post-cursor slice count |
| tap_pre_o | output | 2 | Aligned pre-cursor pair {odd, even} |
| tap_main_o | output | 2 | Aligned main pair {odd, even} |
| tap_post_o | output | 2 | Aligned post-cursor pair {odd, even} |
| pu_n_even_o | output | NSEG | Even-lane pull-up controls, active low |
| pu_n_odd_o | output | NSEG | Odd-lane pull-up controls, active low |
| pd_even_o | output | NSEG | Even-lane pull-down controls, active high |
| pd_odd_o | output | NSEG | Odd-lane pull-down controls, active high |

## Verification
An allocation change and a data transition can land in the same cycle. When they do, a slice that changes role must switch from the old polarity to the new one exactly on the edge that follows the write, with no cycle that mixes old and new. The bench provokes this in two ways: random writes, both legal and oversized, arrive while the data stream runs on, and directed writes are placed on cycles where the data toggles. A reference model judges each cycle. The model applies a write only to the outputs registered one edge after it is sampled, and it checks every slice and lane bit by bit.

// File: rtl/eqmap_pkg.sv
package eqmap_pkg;

  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_MAIN = 2'd1,
    ROLE_PRE  = 2'd2,
    ROLE_POST = 2'd3
  } seg_role_e;

  typedef struct packed {
    logic odd;
    logic even;
  } lane_pair_t;

  typedef struct packed {
    lane_pair_t pre;
    lane_pair_t main;
    lane_pair_t post;
  } tap_set_t;

endpackage

// File: rtl/eqmap_tap_align.sv
module eqmap_tap_align
  import eqmap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] word_i,
  output tap_set_t   taps_nxt_o,
  output tap_set_t   taps_q_o
);

  logic     cur_q, cur_d_unused;
  logic [1:0] cur_word_q;
  logic     prv_odd_q;
  tap_set_t taps_d;
  tap_set_t taps_q;
  logic     primed_q;

  assign cur_q        = cur_word_q[0];
  assign cur_d_unused = 1'b0;

  // next-state: serial order is even then odd within a word
  always_comb begin
    taps_d.main.even = cur_word_q[0];
    taps_d.main.odd  = cur_word_q[1];
    taps_d.pre.even  = cur_word_q[1];
    taps_d.pre.odd   = word_i[0];
    taps_d.post.even = prv_odd_q;
    taps_d.post.odd  = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_word_q <= 2'b00;
      prv_odd_q  <= 1'b0;
      taps_q     <= '0;
      primed_q   <= 1'b0;
    end else begin
      cur_word_q <= word_i;
      prv_odd_q  <= cur_word_q[1];
      taps_q     <= taps_d;
      primed_q   <= 1'b1;
    end
  end

  assign taps_nxt_o = taps_d;
  assign taps_q_o   = taps_q;

  // R2: next serial bit of the odd lane becomes the next main even bit
  p_pre_feeds_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> (taps_q.main.even == $past(taps_q.pre.odd)));

  // R2: current odd main bit becomes the next even post bit
  p_main_feeds_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> (taps_q.post.even == $past(taps_q.main.odd)));

  // R2: main pair follows the input word with one cycle of delay
  p_main_tracks_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> ##1 (taps_q.main == $past(word_i, 2)));

endmodule

// File: rtl/eqmap_alloc_cfg.sv
module eqmap_alloc_cfg #(
  parameter int NSEG = 24,
  parameter int CW   = $clog2(NSEG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_i,
  input  logic [CW-1:0] cfg_pre_i,
  input  logic [CW-1:0] cfg_main_i,
  input  logic [CW-1:0] cfg_post_i,
  output logic [CW-1:0] bnd_main_o,
  output logic [CW-1:0] bnd_pre_o,
  output logic [CW-1:0] bnd_post_o
);

  localparam int SW = CW + 2;
  localparam logic [SW-1:0] LIMIT = SW'(NSEG);

  logic [SW-1:0] req_sum;
  logic          req_legal;
  logic          load_en;
  logic [CW-1:0] bnd_main_d, bnd_pre_d, bnd_post_d;
  logic [CW-1:0] bnd_main_q, bnd_pre_q, bnd_post_q;

  always_comb begin
    req_sum    = SW'(cfg_pre_i) + SW'(cfg_main_i) + SW'(cfg_post_i);
    req_legal  = (req_sum <= LIMIT);
    load_en    = cfg_wr_i & req_legal;
    bnd_main_d = cfg_main_i;
    bnd_pre_d  = CW'(SW'(cfg_main_i) + SW'(cfg_pre_i));
    bnd_post_d = CW'(req_sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_main_q <= CW'(NSEG);
      bnd_pre_q  <= CW'(NSEG);
      bnd_post_q <= CW'(NSEG);
    end else if (load_en) begin
      bnd_main_q <= bnd_main_d;
      bnd_pre_q  <= bnd_pre_d;
      bnd_post_q <= bnd_post_d;
    end
  end

  assign bnd_main_o = bnd_main_q;
  assign bnd_pre_o  = bnd_pre_q;
  assign bnd_post_o = bnd_post_q;

  // R7: held boundaries stay ordered and within the slice count
  p_bounds_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_main_q <= bnd_pre_q) && (bnd_pre_q <= bnd_post_q) &&
    (SW'(bnd_post_q) <= LIMIT));

  // R7: an oversized request leaves the allocation untouched
  p_reject_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && (SW'(cfg_pre_i) + SW'(cfg_main_i) + SW'(cfg_post_i) > LIMIT))
      |=> ($stable(bnd_main_q) && $stable(bnd_pre_q) && $stable(bnd_post_q)));

  // R8: a legal request is visible after the sampling edge
  p_accept_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && (SW'(cfg_pre_i) + SW'(cfg_main_i) + SW'(cfg_post_i) <= LIMIT))
      |=> (bnd_main_q == $past(cfg_main_i)));

endmodule

// File: rtl/eqmap_seg_slice.sv
module eqmap_seg_slice
  import eqmap_pkg::*;
#(
  parameter int IDX = 0,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] bnd_main_i,
  input  logic [CW-1:0] bnd_pre_i,
  input  logic [CW-1:0] bnd_post_i,
  input  tap_set_t      taps_i,
  output logic [1:0]    pu_n_o,
  output logic [1:0]    pd_o
);

  localparam logic [CW-1:0] IDX_V = CW'(IDX);

  seg_role_e  role_d;
  logic       sel_d;
  lane_pair_t bit_d;
  logic [1:0] pu_n_d, pd_d;
  logic [1:0] pu_n_q, pd_q;

  always_comb begin
    if (IDX_V < bnd_main_i)      role_d = ROLE_MAIN;
    else if (IDX_V < bnd_pre_i)  role_d = ROLE_PRE;
    else if (IDX_V < bnd_post_i) role_d = ROLE_POST;
    else                         role_d = ROLE_IDLE;
  end

  always_comb begin
    sel_d = (role_d != ROLE_IDLE);
    unique case (role_d)
      ROLE_MAIN: bit_d = taps_i.main;
      ROLE_PRE:  bit_d = ~taps_i.pre;
      ROLE_POST: bit_d = ~taps_i.post;
      default:   bit_d = '0;
    endcase
    // first-stage gating: NAND for pull-up, NOR for pull-down
    pu_n_d = ~({sel_d, sel_d} & {bit_d.odd, bit_d.even});
    pd_d   = ~({~sel_d, ~sel_d} | {bit_d.odd, bit_d.even});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_n_q <= 2'b11;
      pd_q   <= 2'b00;
    end else begin
      pu_n_q <= pu_n_d;
      pd_q   <= pd_d;
    end
  end

  assign pu_n_o = pu_n_q;
  assign pd_o   = pd_q;

  // R6: never both branches on for a lane
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pu_n_q) & pd_q) == 2'b00);

  // R5: an idle slice goes quiet at the next edge
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (role_d == ROLE_IDLE) |=> (pu_n_q == 2'b11 && pd_q == 2'b00));

  // R4: a selected slice always drives exactly one branch per lane
  p_active_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (role_d != ROLE_IDLE) |=> ((~pu_n_q) ^ pd_q) == 2'b11);

endmodule

// File: rtl/eqmap_seg_mapper.sv
module eqmap_seg_mapper
  import eqmap_pkg::*;
#(
  parameter int NSEG = 24,
  parameter int CW   = $clog2(NSEG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      word_i,
  input  logic            cfg_wr_i,
  input  logic [CW-1:0]   cfg_pre_i,
  input  logic [CW-1:0]   cfg_main_i,
  input  logic [CW-1:0]   cfg_post_i,
  output logic [1:0]      tap_pre_o,
  output logic [1:0]      tap_main_o,
  output logic [1:0]      tap_post_o,
  output logic [NSEG-1:0] pu_n_even_o,
  output logic [NSEG-1:0] pu_n_odd_o,
  output logic [NSEG-1:0] pd_even_o,
  output logic [NSEG-1:0] pd_odd_o
);

  tap_set_t      taps_nxt;
  tap_set_t      taps_q;
  logic [CW-1:0] bnd_main, bnd_pre, bnd_post;

  eqmap_tap_align u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_i     (word_i),
    .taps_nxt_o (taps_nxt),
    .taps_q_o   (taps_q)
  );

  eqmap_alloc_cfg #(.NSEG(NSEG), .CW(CW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_pre_i  (cfg_pre_i),
    .cfg_main_i (cfg_main_i),
    .cfg_post_i (cfg_post_i),
    .bnd_main_o (bnd_main),
    .bnd_pre_o  (bnd_pre),
    .bnd_post_o (bnd_post)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_slice
    logic [1:0] pu_n_s, pd_s;
    eqmap_seg_slice #(.IDX(g), .CW(CW)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .bnd_main_i (bnd_main),
      .bnd_pre_i  (bnd_pre),
      .bnd_post_i (bnd_post),
      .taps_i     (taps_nxt),
      .pu_n_o     (pu_n_s),
      .pd_o       (pd_s)
    );
    assign pu_n_even_o[g] = pu_n_s[0];
    assign pu_n_odd_o[g]  = pu_n_s[1];
    assign pd_even_o[g]   = pd_s[0];
    assign pd_odd_o[g]    = pd_s[1];
  end

  assign tap_pre_o  = taps_q.pre;
  assign tap_main_o = taps_q.main;
  assign tap_post_o = taps_q.post;

  // R6: no lane of any slice drives both branches
  p_array_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((~pu_n_even_o) & pd_even_o) == '0) && (((~pu_n_odd_o) & pd_odd_o) == '0));

endmodule

// File: tb/test_eqmap_seg_mapper.sv
module test_eqmap_seg_mapper;

  localparam int NSEG = 24;
  localparam int CW   = $clog2(NSEG + 1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      word_i;
  logic            cfg_wr_i;
  logic [CW-1:0]   cfg_pre_i, cfg_main_i, cfg_post_i;
  logic [1:0]      tap_pre_o, tap_main_o, tap_post_o;
  logic [NSEG-1:0] pu_n_even_o, pu_n_odd_o, pd_even_o, pd_odd_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model state
  logic [1:0] m_cur;
  logic       m_prv_odd;
  int         m_main, m_pre, m_post;

  always #2.5 clk = ~clk;

  eqmap_seg_mapper #(.NSEG(NSEG), .CW(CW)) i_eqmap_seg_mapper (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .cfg_wr_i(cfg_wr_i),
    .cfg_pre_i(cfg_pre_i), .cfg_main_i(cfg_main_i), .cfg_post_i(cfg_post_i),
    .tap_pre_o(tap_pre_o), .tap_main_o(tap_main_o), .tap_post_o(tap_post_o),
    .pu_n_even_o(pu_n_even_o), .pu_n_odd_o(pu_n_odd_o),
    .pd_even_o(pd_even_o), .pd_odd_o(pd_odd_o)
  );

  task automatic check_vec(input string tag, input string what,
                           input logic [NSEG-1:0] act, input logic [NSEG-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bit used by a slice of given role (0 idle, 1 main, 2 pre, 3 post)
  function automatic int role_of(input int idx, input int m, input int p, input int q);
    if (idx < m) return 1;
    if (idx < m + p) return 2;
    if (idx < m + p + q) return 3;
    return 0;
  endfunction

  task automatic step(input logic [1:0] w, input logic wr,
                      input int p, input int m, input int q, input string tag);
    logic [1:0] e_pre, e_main, e_post;
    logic [NSEG-1:0] e_pue, e_puo, e_pde, e_pdo;
    @(negedge clk);
    word_i     = w;
    cfg_wr_i   = wr;
    cfg_pre_i  = CW'(p);
    cfg_main_i = CW'(m);
    cfg_post_i = CW'(q);
    @(posedge clk);
    // R2 alignment, {odd, even}
    e_main = m_cur;
    e_pre  = {w[0], m_cur[1]};
    e_post = {m_cur[0], m_prv_odd};
    for (int i = 0; i < NSEG; i++) begin
      int r;
      logic [1:0] b;
      r = role_of(i, m_main, m_pre, m_post);
      case (r)
        1: b = e_main;
        2: b = ~e_pre;
        3: b = ~e_post;
        default: b = 2'b00;
      endcase
      if (r == 0) begin
        e_pue[i] = 1'b1; e_puo[i] = 1'b1; e_pde[i] = 1'b0; e_pdo[i] = 1'b0;
      end else begin
        e_pue[i] = ~b[0]; e_puo[i] = ~b[1]; e_pde[i] = ~b[0]; e_pdo[i] = ~b[1];
      end
    end
    m_prv_odd = m_cur[1];
    m_cur     = w;
    if (wr && (p + m + q <= NSEG)) begin
      m_pre = p; m_main = m; m_post = q;
    end
    #1;
    check_vec({tag, " R2"}, "taps", NSEG'({tap_pre_o, tap_main_o, tap_post_o}),
              NSEG'({e_pre, e_main, e_post}));
    check_vec({tag, " R3/R4/R5"}, "pu_n_even", pu_n_even_o, e_pue);
    check_vec({tag, " R3/R4/R5"}, "pu_n_odd", pu_n_odd_o, e_puo);
    check_vec({tag, " R3/R4/R5"}, "pd_even", pd_even_o, e_pde);
    check_vec({tag, " R3/R4/R5"}, "pd_odd", pd_odd_o, e_pdo);
    check_vec({tag, " R6"}, "overlap_even", (~pu_n_even_o) & pd_even_o, '0);
    check_vec({tag, " R6"}, "overlap_odd", (~pu_n_odd_o) & pd_odd_o, '0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0; word_i = 2'b00; cfg_wr_i = 1'b0;
    cfg_pre_i = '0; cfg_main_i = '0; cfg_post_i = '0;
    m_cur = 2'b00; m_prv_odd = 1'b0;
    m_main = NSEG; m_pre = 0; m_post = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check_vec("R1", "pu_n_even", pu_n_even_o, '1);
    check_vec("R1", "pu_n_odd", pu_n_odd_o, '1);
    check_vec("R1", "pd_even", pd_even_o, '0);
    check_vec("R1", "pd_odd", pd_odd_o, '0);
    check_vec("R1", "taps", NSEG'({tap_pre_o, tap_main_o, tap_post_o}), '0);
    rst_n = 1'b1;

    // R1 default allocation: every slice on main
    step(2'b01, 0, 0, 0, 0, "R1");
    step(2'b10, 0, 0, 0, 0, "R1");
    step(2'b11, 0, 0, 0, 0, "R1");
    step(2'b00, 0, 0, 0, 0, "R1");

    // R8 write landing on a data transition
    step(2'b11, 1, 3, 18, 3, "R8");
    step(2'b00, 0, 0, 0, 0, "R8");
    step(2'b01, 0, 0, 0, 0, "R8");

    // R7 oversized request ignored
    step(2'b10, 1, 10, 10, 10, "R7");
    step(2'b01, 0, 0, 0, 0, "R7");
    step(2'b10, 1, 0, 24, 1, "R7");
    step(2'b11, 0, 0, 0, 0, "R7");

    // R9 exact total and zero counts
    step(2'b00, 1, 0, 0, 24, "R9");
    step(2'b11, 0, 0, 0, 0, "R9");
    step(2'b01, 1, 12, 0, 12, "R9");
    step(2'b10, 0, 0, 0, 0, "R9");
    step(2'b01, 1, 0, 0, 0, "R9 R5");
    step(2'b10, 0, 0, 0, 0, "R9 R5");
    step(2'b11, 0, 0, 0, 0, "R9 R5");
    step(2'b00, 1, 5, 14, 5, "R8");

    // random stream with legal and oversized writes
    for (int n = 0; n < 3000; n++) begin
      logic wr;
      int p, m, q;
      wr = ($urandom % 8) == 0;
      p = $urandom % (NSEG + 1);
      m = $urandom % (NSEG + 1);
      q = $urandom % (NSEG + 1);
      if (($urandom % 2) == 0 && (p + m + q > NSEG)) begin
        m = NSEG - p - q;
        if (m < 0) begin m = 0; q = NSEG - p; end
      end
      step(2'($urandom), wr, p, m, q, "R2/R3/R4/R7/R8");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule